// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Flags

This block counts cycles of the system base clock and requests a chip reset when software stops servicing it. Software picks one of four timeout lengths through a 2-bit select field. That field can be written only once after each reset. Software keeps the timer quiet by writing the key byte 0x5A to a service address. If servicing stops, a one-cycle reset request is raised between one and two selected periods after the last valid service.

The same register also records why the chip was last reset. One flag is set by the watchdog's own request. Another is set by a software-reset request pulse. Both flags are cleared by the external pin reset and by reading the register. A plain strobed register bus gives access: read strobe, write strobe, address and write data, with the read data registered. A parameter shortens all four periods by the same factor so the block can be simulated.

Top module: `wdog_top`

## Requirements
- R1: With select code k (0..3) and no service, the first reset request appears on `wdt_rst_o` after clock edge 2P, counting edges from the release of reset. Here P = 2^(EXP_BASE + 2k); EXP_BASE is 16 by default.
- R2: A write of 0x5A in `bus_wdata_i[7:0]` to SVC_ADDR at edge s moves the next request to edge P*(floor(s/P)+2). This places it between P+1 and 2P edges after the service.
- R3: A service write at the same edge as a period boundary takes priority, so that boundary neither arms nor fires the timer. Any service byte other than 0x5A has no effect.
- R4: `wdt_rst_o` is high for exactly one cycle per request. Without further service, requests repeat every 2P edges.
- R5: The select field is status bits [9:8]. Only the first write to STAT_ADDR after `sys_rst_i` or `pin_init_i` changes it, even when that write is 00. Later writes are ignored. Both resets return the field to 00.
- R6: Status bit 13 is set on the cycle after a reset request. Status bit 11 is set on the cycle after a `swrst_req_i` pulse.
- R7: A read strobe to STAT_ADDR at edge k shows the register on `bus_rdata_o` after edge k. Both flags are cleared at that edge. A flag-setting event at the same edge leaves the flag set.
- R8: `pin_init_i` clears both flags. `sys_rst_i` leaves them unchanged.
- R9: Writes to STAT_ADDR never change bits 13 or 11.
- R10: Status bits other than 13, 11, 9 and 8 read as 0. A read of any other address returns 0. `bus_rdata_o` is 0 in a cycle with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System base clock |
| pin_init_i | input | 1 | Synchronous reset from the external pin; also clears the cause flags |
| sys_rst_i | input | 1 | Synchronous internal reset; keeps the cause flags |
| swrst_req_i | input | 1 | One-cycle software-reset request pulse |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| wdt_rst_o | output | 1 | One-cycle watchdog reset request |

## Verification
The bench uses EXP_BASE = 2, which makes the four periods 4, 16, 64 and 256 edges. Each period is run with a fixed service pattern:
- A service on a period boundary tells apart a design where service takes priority from one where the boundary fires first.
- A service one edge before a boundary exposes the short edge of the window.
- A long unserviced stretch confirms that requests repeat.
- A wrong key shows that the key is compared.

Register sequences then cover the flag paths:
- A read that coincides with a software-reset pulse.
- An internal reset against a pin reset.
- Writes of all ones and all zeros.
These separate correct set/clear priority from the plausible wrong orderings.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int NUM_SEL      = 4;
  localparam int SEL_W        = 2;
  localparam int FLAG_WDT_BIT = 13;
  localparam int FLAG_SW_BIT  = 11;
  localparam int SEL_LSB      = 8;
  localparam logic [7:0] SVC_KEY = 8'h5A;

  typedef logic [SEL_W-1:0] sel_t;
endpackage

// File: rtl/wdog_sel_reg.sv
module wdog_sel_reg
  import wdog_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic wr_i,
  input  sel_t sel_i,
  output sel_t sel_o,
  output logic locked_o
);
  sel_t sel_q;
  logic lock_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sel_q  <= '0;
      lock_q <= 1'b0;
    end else if (wr_i && !lock_q) begin
      sel_q  <= sel_i;
      lock_q <= 1'b1;
    end
  end

  assign sel_o    = sel_q;
  assign locked_o = lock_q;
endmodule

// File: rtl/wdog_timebase.sv
module wdog_timebase
  import wdog_pkg::*;
#(
  parameter int EXP_BASE = 16
) (
  input  logic clk_i,
  input  logic rst_i,
  input  sel_t sel_i,
  input  logic service_i,
  output logic pend_o,
  output logic fire_o
);
  localparam int CNT_W = EXP_BASE + 2 * (NUM_SEL - 1);

  logic [CNT_W-1:0]   cnt_q;
  logic [NUM_SEL-1:0] tick_vec;
  logic               tick;
  logic               pend_q;
  logic               fire_q;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_tick
    localparam int EXP = EXP_BASE + 2 * g;
    assign tick_vec[g] = &cnt_q[EXP-1:0];
  end

  assign tick = tick_vec[sel_i];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      fire_q <= 1'b0;
      if (service_i) begin
        pend_q <= 1'b0;
      end else if (tick) begin
        if (pend_q) begin
          fire_q <= 1'b1;
          pend_q <= 1'b0;
        end else begin
          pend_q <= 1'b1;
        end
      end
    end
  end

  assign pend_o = pend_q;
  assign fire_o = fire_q;
endmodule

// File: rtl/wdog_cause_reg.sv
module wdog_cause_reg (
  input  logic clk_i,
  input  logic init_i,
  input  logic set_wdt_i,
  input  logic set_sw_i,
  input  logic rd_clr_i,
  output logic flag_wdt_o,
  output logic flag_sw_o
);
  logic wdt_q;
  logic sw_q;

  always_ff @(posedge clk_i) begin
    if (init_i) begin
      wdt_q <= 1'b0;
      sw_q  <= 1'b0;
    end else begin
      wdt_q <= set_wdt_i | (wdt_q & ~rd_clr_i);
      sw_q  <= set_sw_i  | (sw_q  & ~rd_clr_i);
    end
  end

  assign flag_wdt_o = wdt_q;
  assign flag_sw_o  = sw_q;
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 16,
  parameter int EXP_BASE  = 16,
  parameter int STAT_ADDR = 0,
  parameter int SVC_ADDR  = 1
) (
  input  logic              clk_i,
  input  logic              pin_init_i,
  input  logic              sys_rst_i,
  input  logic              swrst_req_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              wdt_rst_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_SVC  = ADDR_W'(SVC_ADDR);

  logic rst_any;
  logic hit_stat;
  logic hit_svc;
  logic stat_wr;
  logic stat_rd;
  logic service;
  sel_t sel_code;
  logic sel_locked;
  logic pend;
  logic fire;
  logic flag_wdt;
  logic flag_sw;
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] rdata_q;
  logic unused_wdata_hi;

  assign rst_any  = pin_init_i | sys_rst_i;
  assign hit_stat = (bus_addr_i == A_STAT);
  assign hit_svc  = (bus_addr_i == A_SVC);
  assign stat_wr  = bus_wr_i & hit_stat;
  assign stat_rd  = bus_rd_i & hit_stat;
  assign service  = bus_wr_i & hit_svc & (bus_wdata_i[7:0] == SVC_KEY);
  assign unused_wdata_hi = ^bus_wdata_i[DATA_W-1:SEL_LSB+SEL_W];

  wdog_sel_reg u_sel (
    .clk_i    (clk_i),
    .rst_i    (rst_any),
    .wr_i     (stat_wr),
    .sel_i    (bus_wdata_i[SEL_LSB +: SEL_W]),
    .sel_o    (sel_code),
    .locked_o (sel_locked)
  );

  wdog_timebase #(.EXP_BASE(EXP_BASE)) u_tb (
    .clk_i     (clk_i),
    .rst_i     (rst_any),
    .sel_i     (sel_code),
    .service_i (service),
    .pend_o    (pend),
    .fire_o    (fire)
  );

  wdog_cause_reg u_cause (
    .clk_i      (clk_i),
    .init_i     (pin_init_i),
    .set_wdt_i  (fire),
    .set_sw_i   (swrst_req_i),
    .rd_clr_i   (stat_rd),
    .flag_wdt_o (flag_wdt),
    .flag_sw_o  (flag_sw)
  );

  always_comb begin
    stat_word = '0;
    stat_word[FLAG_WDT_BIT] = flag_wdt;
    stat_word[FLAG_SW_BIT]  = flag_sw;
    stat_word[SEL_LSB +: SEL_W] = sel_code;
  end

  always_ff @(posedge clk_i) begin
    if (rst_any) begin
      rdata_q <= '0;
    end else if (stat_rd) begin
      rdata_q <= stat_word;
    end else begin
      rdata_q <= '0;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign wdt_rst_o   = fire;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              pin_init_i,
  input logic              sys_rst_i,
  input logic              swrst_req_i,
  input logic              bus_rd_i,
  input logic              wdt_rst_o,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              flag_wdt,
  input logic              flag_sw,
  input logic              pend,
  input sel_t              sel_code,
  input logic              sel_locked
);
  localparam logic [DATA_W-1:0] USED_MASK =
    (DATA_W'(1) << FLAG_WDT_BIT) | (DATA_W'(1) << FLAG_SW_BIT) |
    (DATA_W'(3) << SEL_LSB);

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (pin_init_i || sys_rst_i)
    wdt_rst_o |=> !wdt_rst_o); // R4
  AST_FIRE_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (pin_init_i || sys_rst_i)
    $rose(wdt_rst_o) |-> $past(pend)); // R2
  AST_WDT_FLAG_SET: assert property (@(posedge clk_i) disable iff (pin_init_i)
    wdt_rst_o |=> flag_wdt); // R6
  AST_SW_FLAG_SET: assert property (@(posedge clk_i) disable iff (pin_init_i)
    swrst_req_i |=> flag_sw); // R6
  AST_INIT_CLEARS: assert property (@(posedge clk_i) disable iff (sys_rst_i)
    pin_init_i |=> (!flag_wdt && !flag_sw)); // R8
  AST_SEL_LOCKED: assert property (@(posedge clk_i) disable iff (pin_init_i || sys_rst_i)
    sel_locked |=> $stable(sel_code)); // R5
  AST_RDATA_IDLE: assert property (@(posedge clk_i) disable iff (pin_init_i || sys_rst_i)
    !bus_rd_i |=> (bus_rdata_o == '0)); // R10
  AST_RESERVED_ZERO: assert property (@(posedge clk_i) disable iff (pin_init_i)
    (bus_rdata_o & ~USED_MASK) == '0); // R10
endmodule

bind wdog_top wdog_checker #(.DATA_W(DATA_W)) chk_i (
  .clk_i       (clk_i),
  .pin_init_i  (pin_init_i),
  .sys_rst_i   (sys_rst_i),
  .swrst_req_i (swrst_req_i),
  .bus_rd_i    (bus_rd_i),
  .wdt_rst_o   (wdt_rst_o),
  .bus_rdata_o (bus_rdata_o),
  .flag_wdt    (flag_wdt),
  .flag_sw     (flag_sw),
  .pend        (pend),
  .sel_code    (sel_code),
  .sel_locked  (sel_locked)
);

// File: tb/wdog_top_tb_top.sv
module wdog_top_tb_top;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 16;
  localparam int EXP_B  = 2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] A_SVC  = 2'd1;
  localparam logic [ADDR_W-1:0] A_OTHER = 2'd2;

  logic clk = 1'b0;
  logic pin_init = 1'b1;
  logic sys_rst = 1'b1;
  logic swrst = 1'b0;
  logic rd = 1'b0;
  logic wr = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic wdt_rst;

  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  wdog_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EXP_BASE(EXP_B)) dut_i (
    .clk_i(clk), .pin_init_i(pin_init), .sys_rst_i(sys_rst), .swrst_req_i(swrst),
    .bus_rd_i(rd), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .wdt_rst_o(wdt_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic apply_rst(input logic with_pin);
    pin_init = with_pin;
    sys_rst  = 1'b1;
    step(); step(); step();
    pin_init = 1'b0;
    sys_rst  = 1'b0;
  endtask

  task automatic rd_reg(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] v);
    rd = 1'b1; addr = a;
    step();
    v = rdata;
    rd = 1'b0; addr = '0;
  endtask

  task automatic wr_reg(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    wr = 1'b1; addr = a; wdata = d;
    step();
    wr = 1'b0; addr = '0; wdata = '0;
  endtask

  initial begin
    logic [DATA_W-1:0] v;
    step();
    apply_rst(1'b1);
    chk("R10 reset rdata", rdata, 0);
    chk("R4 reset request", wdt_rst, 0);

    for (int c = 0; c < 4; c++) begin
      int p;
      p = 1 << (EXP_B + 2 * c);
      apply_rst(1'b0);
      for (int e = 1; e <= 9 * p + 1; e++) begin
        logic exp_fire;
        wr = 1'b0; addr = '0; wdata = '0;
        if (e == 1) begin
          wr = 1'b1; addr = A_STAT; wdata = DATA_W'(c) << 8;
        end else if (e == 2) begin
          wr = 1'b1; addr = A_STAT; wdata = DATA_W'(3 - c) << 8;
        end else if (e == 2 * p || e == 4 * p - 1) begin
          wr = 1'b1; addr = A_SVC; wdata = 16'h005A;
        end else if (e == 8 * p + 1) begin
          wr = 1'b1; addr = A_SVC; wdata = 16'h00A5;
        end
        step();
        wr = 1'b0; addr = '0; wdata = '0;
        exp_fire = (e == 5 * p) || (e == 7 * p) || (e == 9 * p);
        if (e == 2 * p || e == 4 * p) chk("R3 service on boundary", wdt_rst, exp_fire);
        else if (e == 5 * p) chk("R2 window lower edge", wdt_rst, exp_fire);
        else if (e == 7 * p || e == 7 * p + 1) chk("R4 repeat pulse", wdt_rst, exp_fire);
        else if (e == 9 * p) chk("R3 wrong key ignored", wdt_rst, exp_fire);
        else chk("R2 timing", wdt_rst, exp_fire);
      end
      rd_reg(A_STAT, v);
      chk("R5 R6 status after run", v, 32'h2000 | (c << 8));
      rd_reg(A_STAT, v);
      chk("R7 read clears flag", v, c << 8);
      step();
      chk("R10 idle rdata", rdata, 0);
    end

    // R1: unserviced code 0, first request at edge 8
    apply_rst(1'b0);
    for (int e = 1; e <= 9; e++) begin
      step();
      chk("R1 unserviced period", wdt_rst, e == 8);
    end
    swrst = 1'b1; step(); swrst = 1'b0;
    apply_rst(1'b1);
    rd_reg(A_STAT, v);
    chk("R8 pin init clears flags", v, 0);

    swrst = 1'b1; step(); swrst = 1'b0;
    rd_reg(A_STAT, v);
    chk("R6 sw flag", v, 16'h0800);
    rd_reg(A_STAT, v);
    chk("R7 sw flag cleared by read", v, 0);

    swrst = 1'b1; step(); swrst = 1'b0;
    apply_rst(1'b0);
    rd_reg(A_STAT, v);
    chk("R8 internal reset keeps flag", v, 16'h0800);

    swrst = 1'b1;
    rd_reg(A_STAT, v);
    swrst = 1'b0;
    chk("R7 read with coincident set", v, 0);
    rd_reg(A_STAT, v);
    chk("R7 set wins over clear", v, 16'h0800);

    wr_reg(A_STAT, 16'hFFFF);
    rd_reg(A_STAT, v);
    chk("R9 write ones keeps flags", v, 16'h0300);

    swrst = 1'b1; step(); swrst = 1'b0;
    wr_reg(A_STAT, 16'h0000);
    rd_reg(A_STAT, v);
    chk("R9 R5 write zeros locked", v, 16'h0B00);

    apply_rst(1'b0);
    wr_reg(A_STAT, 16'h0000);
    wr_reg(A_STAT, 16'h0200);
    rd_reg(A_STAT, v);
    chk("R5 first write of 00 locks", v, 0);

    rd_reg(A_SVC, v);
    chk("R10 other address reads zero", v, 0);
    rd_reg(A_OTHER, v);
    chk("R10 unused address reads zero", v, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (all) actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule